// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit linear address into a physical address. It reads one entry from each of four levels of page tables held in memory, starting from a root register. A requester presents the linear address, the kind of access (read, write or instruction fetch) and the current privilege level. The walker then issues up to four 64-bit entry reads, one at a time, on a request/response memory port. It answers with either the physical address or a fault cause.

Each table holds 512 entries of 8 bytes. A 9-bit index field of the linear address selects the entry at each level. The entry address is the table base plus eight times that index. The low 12 address bits are the byte offset and pass through unchanged.

Before any read, an address whose upper bits do not repeat bit 47 is refused. Along the walk the writable and user flags are ANDed across the levels, and the no-execute flags are ORed. The result is judged against the access once the last entry arrives.

The controller is a four-state machine:
- IDLE waits for a request. On a canonical address it takes the transition IDLE→ISSUE. On a non-canonical address it takes IDLE→DONE.
- ISSUE holds a memory read until the memory accepts it (ISSUE→WAIT).
- WAIT takes the entry. It goes back WAIT→ISSUE for the next level, or WAIT→DONE when the entry is not present or was the last one.
- DONE presents the answer for one cycle and returns DONE→IDLE.

Top module: `page_walker`

## Requirements
- R1: For a linear address `va`, the walker reads levels 4, 3, 2, 1 in that order. The index fields are va[47:39], va[38:30], va[29:21] and va[20:12]. The level-4 table base is root_reg[51:12]·4096. Each later base is bits 51:12 of the previous entry ·4096. The read address is base + 8·index, so mem_req_addr[2:0] is always 0.
- R2: When no fault occurs, res_paddr = {final entry[51:12], va[11:0]}, res_fault = 0 and res_level = 1.
- R3: A linear address whose bits 63:48 are not all equal to bit 47 gives res_fault = 1 and res_level = 0. No memory read is made, and the result appears in the cycle after acceptance.
- R4: An entry with bit 0 (present) clear ends the walk at once. The result is res_fault = 2, and res_level gives the level (4..1) of that entry. No further reads follow.
- R5: For a write (req_acc = 1), every one of the four entries must have bit 1 set, otherwise res_fault = 3.
- R6: For req_cpl = 3 (user access), every entry must have bit 2 set, otherwise res_fault = 4. When req_cpl is 0, 1 or 2, bit 2 has no effect.
- R7: For a fetch (req_acc = 2), bit 63 set in any entry gives res_fault = 5. For reads and writes, bit 63 has no effect.
- R8: A not-present fault takes precedence over every permission fault. Among the permission faults, write-protect (3) wins over user (4), and user wins over no-execute (5). On any fault res_paddr = 0.
- R9: req_ready is high only while idle. It drops in the cycle after acceptance and stays low until the result has been shown. res_valid lasts exactly one cycle. A memory request holds its address until accepted, and only one read is outstanding at a time.
- R10: After reset, req_ready = 1, res_valid = 0 and mem_req_valid = 0.
- R11: Some bits never change a read address or a result: root_reg bits 63:52 and 11:0, and entry bits 62:52 and 11:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_reg | input | 64 | Root register; bits 51:12 locate the level-4 table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 64 | Linear address |
| req_acc | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| req_cpl | input | 2 | Privilege level; 3 is user |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid strobe |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result strobe, one cycle |
| res_paddr | output | 52 | Physical address (0 on fault) |
| res_fault | output | 3 | Fault cause 0..5 |
| res_level | output | 3 | Level where the walk stopped; 0 for non-canonical |

## Verification
On the last entry's arrival, not-present detection and the accumulated permission decision are both resolved in the same cycle. The bench provokes this with final entries that are absent while upper levels already deny a write. Other cases stack several permission failures at once: a user write through read-only, supervisor-only levels, and a user fetch through supervisor-only, no-execute levels. Each such walk is judged by the single cause and level the scoreboard predicts from the precedence rule. The same walks are repeated under a memory that stalls requests and delays answers, so that response timing cannot change the outcome.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_NONCANON   = 3'd1,
        FLT_NOTPRESENT = 3'd2,
        FLT_WRPROT     = 3'd3,
        FLT_USER       = 3'd4,
        FLT_NOEXEC     = 3'd5
    } fault_e;

    localparam int ENT_P  = 0;
    localparam int ENT_RW = 1;
    localparam int ENT_US = 2;
    localparam int ENT_NX = 63;
endpackage

// File: rtl/pw_canon_check.sv
module pw_canon_check #(
    parameter int VA_BITS = 48
) (
    input  logic [63:VA_BITS-1] upper_bits,
    output logic                ok
);
    // all copies of the top significant bit must agree
    always_comb begin
        ok = (&upper_bits) | ~(|upper_bits);
    end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int PA_BITS   = 52,
    parameter int VA_BITS   = 48,
    parameter int PAGE_BITS = 12,
    parameter int IDX_BITS  = 9,
    parameter int LEVELS    = 4,
    parameter int LVL_W     = 2
) (
    input  logic [PA_BITS-PAGE_BITS-1:0] frame,
    input  logic [VA_BITS-PAGE_BITS-1:0] vpn,
    input  logic [LVL_W-1:0]             lvl,
    output logic [PA_BITS-1:0]           addr
);
    localparam int ENT_SHIFT = PAGE_BITS - IDX_BITS;

    logic [IDX_BITS-1:0] idx_by_lvl [LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_by_lvl[g] = vpn[g*IDX_BITS +: IDX_BITS];
    end

    always_comb begin
        idx_sel = idx_by_lvl[lvl];
        addr    = {frame, idx_sel, {ENT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/pw_perm_eval.sv
module pw_perm_eval
    import pw_pkg::*;
(
    input  logic       rw_all,
    input  logic       us_all,
    input  logic       nx_any,
    input  logic       user_mode,
    input  logic [1:0] acc,
    output fault_e     fault
);
    always_comb begin
        fault = FLT_NONE;
        if (acc_e'(acc) == ACC_WRITE && !rw_all) begin
            fault = FLT_WRPROT;
        end else if (user_mode && !us_all) begin
            fault = FLT_USER;
        end else if (acc_e'(acc) == ACC_FETCH && nx_any) begin
            fault = FLT_NOEXEC;
        end
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
#(
    parameter int VA_BITS   = 48,
    parameter int PA_BITS   = 52,
    parameter int PAGE_BITS = 12,
    parameter int IDX_BITS  = 9,
    parameter int LEVELS    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        root_reg,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [63:0]        req_laddr,
    input  logic [1:0]         req_acc,
    input  logic [1:0]         req_cpl,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_BITS-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [63:0]        mem_rsp_data,
    output logic               res_valid,
    output logic [PA_BITS-1:0] res_paddr,
    output logic [2:0]         res_fault,
    output logic [2:0]         res_level
);
    localparam int FRAME_W = PA_BITS - PAGE_BITS;
    localparam int VPN_W   = VA_BITS - PAGE_BITS;
    localparam int LVL_W   = $clog2(LEVELS);
    localparam int RLVL_W  = 3;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

    state_e               state, nxt;
    logic [VA_BITS-1:0]   laddr_q;
    logic [1:0]           acc_q;
    logic                 user_q;
    logic [LVL_W-1:0]     lvl_q;
    logic [FRAME_W-1:0]   base_q;
    logic                 rw_all_q, us_all_q, nx_any_q;
    fault_e               fault_q;
    logic [RLVL_W-1:0]    level_q;
    logic [PA_BITS-1:0]   paddr_q;

    logic                 canon_ok;
    logic                 ent_present;
    logic                 rw_nxt, us_nxt, nx_nxt;
    fault_e               perm_fault;
    logic                 last_lvl;
    logic                 unused_bits;

    pw_canon_check #(.VA_BITS(VA_BITS)) u_canon (
        .upper_bits (req_laddr[63:VA_BITS-1]),
        .ok         (canon_ok)
    );

    pw_addr_gen #(
        .PA_BITS(PA_BITS), .VA_BITS(VA_BITS), .PAGE_BITS(PAGE_BITS),
        .IDX_BITS(IDX_BITS), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_addr (
        .frame (base_q),
        .vpn   (laddr_q[VA_BITS-1:PAGE_BITS]),
        .lvl   (lvl_q),
        .addr  (mem_req_addr)
    );

    // flags folded with the entry now arriving
    always_comb begin
        ent_present = mem_rsp_data[ENT_P];
        rw_nxt      = rw_all_q & mem_rsp_data[ENT_RW];
        us_nxt      = us_all_q & mem_rsp_data[ENT_US];
        nx_nxt      = nx_any_q | mem_rsp_data[ENT_NX];
        last_lvl    = (lvl_q == '0);
    end

    pw_perm_eval u_perm (
        .rw_all    (rw_nxt),
        .us_all    (us_nxt),
        .nx_any    (nx_nxt),
        .user_mode (user_q),
        .acc       (acc_q),
        .fault     (perm_fault)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_valid) nxt = canon_ok ? S_ISSUE : S_DONE;
            S_ISSUE: if (mem_req_ready) nxt = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) nxt = (!ent_present || last_lvl) ? S_DONE : S_ISSUE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        res_valid     = 1'b0;
        unique case (state)
            S_IDLE:  req_ready     = 1'b1;
            S_ISSUE: mem_req_valid = 1'b1;
            S_WAIT:  ;
            S_DONE:  res_valid     = 1'b1;
            default: ;
        endcase
        res_paddr = paddr_q;
        res_fault = fault_q;
        res_level = level_q;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q  <= '0;
            acc_q    <= '0;
            user_q   <= 1'b0;
            lvl_q    <= '0;
            base_q   <= '0;
            rw_all_q <= 1'b0;
            us_all_q <= 1'b0;
            nx_any_q <= 1'b0;
            fault_q  <= FLT_NONE;
            level_q  <= '0;
            paddr_q  <= '0;
        end else if (state == S_IDLE && req_valid) begin
            laddr_q  <= req_laddr[VA_BITS-1:0];
            acc_q    <= req_acc;
            user_q   <= (req_cpl == 2'd3);
            lvl_q    <= LVL_W'(LEVELS - 1);
            base_q   <= root_reg[PA_BITS-1:PAGE_BITS];
            rw_all_q <= 1'b1;
            us_all_q <= 1'b1;
            nx_any_q <= 1'b0;
            fault_q  <= canon_ok ? FLT_NONE : FLT_NONCANON;
            level_q  <= '0;
            paddr_q  <= '0;
        end else if (state == S_WAIT && mem_rsp_valid) begin
            if (!ent_present) begin
                fault_q <= FLT_NOTPRESENT;
                level_q <= RLVL_W'(lvl_q) + RLVL_W'(1);
            end else if (last_lvl) begin
                fault_q <= perm_fault;
                level_q <= RLVL_W'(1);
                if (perm_fault == FLT_NONE)
                    paddr_q <= {mem_rsp_data[PA_BITS-1:PAGE_BITS], laddr_q[PAGE_BITS-1:0]};
            end else begin
                rw_all_q <= rw_nxt;
                us_all_q <= us_nxt;
                nx_any_q <= nx_nxt;
                base_q   <= mem_rsp_data[PA_BITS-1:PAGE_BITS];
                lvl_q    <= lvl_q - LVL_W'(1);
            end
        end
    end

    assign unused_bits = ^{root_reg[63:PA_BITS], root_reg[PAGE_BITS-1:0],
                           mem_rsp_data[62:PA_BITS], mem_rsp_data[PAGE_BITS-1:3]};
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int VA_BITS = 48,
    parameter int PA_BITS = 52
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [63:0]        req_laddr,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [PA_BITS-1:0] mem_req_addr,
    input logic               res_valid,
    input logic [2:0]         res_fault,
    input logic [2:0]         res_level
);
    logic accept, bad_addr;
    assign accept   = req_valid && req_ready;
    assign bad_addr = req_laddr != {{(64-VA_BITS){req_laddr[VA_BITS-1]}}, req_laddr[VA_BITS-1:0]};

    a_r1_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

    a_r2_success_level: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 3'd0) |-> res_level == 3'd1);

    a_r3_noncanon_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad_addr) |=> (res_valid && res_fault == 3'd1 && res_level == 3'd0));

    a_r3_noncanon_noread: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad_addr) |=> !mem_req_valid);

    a_r4_np_level: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 3'd2) |-> (res_level >= 3'd1 && res_level <= 3'd4));

    a_r8_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_fault <= 3'd5);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    a_r9_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r9_no_ready_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind page_walker pw_checker #(.VA_BITS(VA_BITS), .PA_BITS(PA_BITS)) u_pw_checker (.*);

// File: tb/tb_page_walker.sv
module tb_page_walker;
    localparam logic [51:0] ROOT = 52'h0_0000_0010_0000;
    localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FX = 64'h8000_0000_0000_0000;
    localparam logic [63:0] FULL = 64'h7;

    typedef struct packed {
        logic [51:0] pa;
        logic [2:0]  f;
        logic [2:0]  lv;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [63:0] root_reg;
    logic        req_valid = 1'b0, req_ready;
    logic [63:0] req_laddr = '0;
    logic [1:0]  req_acc = '0, req_cpl = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        res_valid;
    logic [51:0] res_paddr;
    logic [2:0]  res_fault, res_level;

    logic [63:0] mem [logic [51:0]];
    logic [51:0] rd_log[$];
    exp_t        sb[$];
    string       tag_q[$];
    int          n_chk = 0, n_fail = 0, reads = 0, lat = 1;
    bit          stall_mode = 1'b0;
    int          stall_cnt = 0;
    logic [51:0] next_tbl = 52'h0_0000_0020_0000;

    page_walker dut (
        .clk(clk), .rst_n(rst_n), .root_reg(root_reg),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_acc(req_acc), .req_cpl(req_cpl),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault), .res_level(res_level)
    );

    initial forever #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [51:0] idx_off(input logic [63:0] va, input int lvl);
        logic [8:0] ix;
        ix = va[12 + 9*(lvl-1) +: 9];
        return {40'd0, ix, 3'b000};
    endfunction

    // junk in ignored fields (R11): bits 62:52 and 6:5
    function automatic logic [63:0] ent(input logic [51:0] base, input logic [63:0] fl);
        return fl | {1'b0, 11'h7A5, base[51:12], 12'h060};
    endfunction

    logic [51:0] exp_rd[4];

    task automatic build(input logic [63:0] va, input logic [51:0] pf,
                         input logic [63:0] f4, input logic [63:0] f3,
                         input logic [63:0] f2, input logic [63:0] f1);
        logic [51:0] t3, t2, t1;
        t3 = next_tbl; t2 = next_tbl + 52'h1000; t1 = next_tbl + 52'h2000;
        next_tbl = next_tbl + 52'h3000;
        exp_rd[0] = ROOT + idx_off(va, 4);
        exp_rd[1] = t3 + idx_off(va, 3);
        exp_rd[2] = t2 + idx_off(va, 2);
        exp_rd[3] = t1 + idx_off(va, 1);
        mem[exp_rd[0]] = ent(t3, f4);
        mem[exp_rd[1]] = ent(t2, f3);
        mem[exp_rd[2]] = ent(t1, f2);
        mem[exp_rd[3]] = ent(pf, f1);
    endtask

    task automatic walk(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] cpl,
                        input logic [51:0] pa, input logic [2:0] f, input logic [2:0] lv,
                        input int nreads, input string tag);
        exp_t e;
        e.pa = pa; e.f = f; e.lv = lv;
        sb.push_back(e);
        tag_q.push_back(tag);
        reads = 0;
        rd_log.delete();
        @(negedge clk);
        req_laddr = va; req_acc = acc; req_cpl = cpl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 ready low after accept"}, 64'(req_ready), 64'd0);
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check({tag, " read count"}, 64'(reads), 64'(nreads));
    endtask

    // memory model: ready set first, then handshake seen for the coming edge
    initial begin
        logic [51:0] a;
        mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            stall_cnt++;
            mem_req_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                a = mem_req_addr;
                rd_log.push_back(a);
                reads++;
                repeat (lat) @(negedge clk);
                mem_rsp_data = mem.exists(a) ? mem[a] : 64'd0;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (sb.size() == 0) begin
                    check("R9 unexpected result", 64'd1, 64'd0);
                end else begin
                    e = sb.pop_front();
                    t = tag_q.pop_front();
                    check({t, " paddr"}, 64'(res_paddr), 64'(e.pa));
                    check({t, " fault"}, 64'(res_fault), 64'(e.f));
                    check({t, " level"}, 64'(res_level), 64'(e.lv));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] va;
        logic [51:0] pf;
        root_reg = {12'hABC, ROOT[51:12], 12'hFA5}; // R11 junk in ignored root bits
        repeat (3) @(negedge clk);
        check("R10 req_ready", 64'(req_ready), 64'd1);
        check("R10 res_valid", 64'(res_valid), 64'd0);
        check("R10 mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 / R11 lower-half success
        va = 64'h0000_1234_5678_9ABC; pf = 52'h0_00AB_CDEF_0000;
        build(va, pf, FULL, FULL, FULL, FULL);
        walk(va, 2'd0, 2'd0, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R2 lower read");
        for (int i = 0; i < 4; i++)
            check($sformatf("R1 R11 read address level %0d", 4 - i), 64'(rd_log[i]), 64'(exp_rd[i]));

        // R2 upper half
        va = 64'hFFFF_FFFF_8100_0ABC; pf = 52'h0_0000_0123_4000;
        build(va, pf, FULL, FULL, FULL, FULL);
        walk(va, 2'd0, 2'd0, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R2 upper read");

        // R3 non-canonical
        walk(64'h0001_0000_0000_0000, 2'd0, 2'd0, '0, 3'd1, 3'd0, 0, "R3 upper zeros bit48");
        walk(64'hFFFF_0000_0000_0000, 2'd1, 2'd0, '0, 3'd1, 3'd0, 0, "R3 ones over bit47 clear");
        walk(64'h0000_8000_0000_0000, 2'd2, 2'd3, '0, 3'd1, 3'd0, 0, "R3 zeros over bit47 set");

        // R4 not-present at several levels
        va = 64'h0000_0040_0000_1000; build(va, 52'h1000, 64'h0, FULL, FULL, FULL);
        walk(va, 2'd0, 2'd0, '0, 3'd2, 3'd4, 1, "R4 level4");
        va = 64'h0000_0080_4020_2000; build(va, 52'h1000, FULL, FULL, 64'h0, FULL);
        walk(va, 2'd0, 2'd0, '0, 3'd2, 3'd2, 3, "R4 level2");
        va = 64'h0000_00C0_8040_3000; build(va, 52'h1000, FULL, FULL, FULL, FW | FU);
        walk(va, 2'd0, 2'd0, '0, 3'd2, 3'd1, 4, "R4 level1");

        // R5 write protection
        va = 64'h0000_0100_0000_4123; pf = 52'h0_0000_5555_5000;
        build(va, pf, FULL, FP | FU, FULL, FULL);
        walk(va, 2'd1, 2'd0, '0, 3'd3, 3'd1, 4, "R5 write ro level3");
        walk(va, 2'd0, 2'd0, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R5 read ro ok");
        build(va, pf, FULL, FULL, FULL, FULL);
        walk(va, 2'd1, 2'd0, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R5 write rw ok");

        // R6 user privilege
        va = 64'h0000_0140_1234_5678; pf = 52'h0_0000_0777_7000;
        build(va, pf, FULL, FULL, FULL, FP | FW);
        walk(va, 2'd0, 2'd3, '0, 3'd4, 3'd1, 4, "R6 user on supervisor page");
        walk(va, 2'd1, 2'd2, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R6 cpl2 ignores us");

        // R7 no-execute
        va = 64'hFFFF_A000_0000_0FFF; pf = 52'h0_0000_0999_9000;
        build(va, pf, FULL, FULL, FULL | FX, FULL);
        walk(va, 2'd2, 2'd0, '0, 3'd5, 3'd1, 4, "R7 fetch nx level2");
        walk(va, 2'd0, 2'd3, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R7 read ignores nx");
        build(va, pf, FULL, FULL, FULL, FULL);
        walk(va, 2'd2, 2'd3, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R7 fetch allowed");

        // R8 precedence
        va = 64'h0000_0200_0000_0000; build(va, 52'h3000, FP | FU, FULL, FULL, 64'h0);
        walk(va, 2'd1, 2'd0, '0, 3'd2, 3'd1, 4, "R8 np over write");
        build(va, 52'h3000, FULL, FULL, FP, FULL);
        walk(va, 2'd1, 2'd3, '0, 3'd3, 3'd1, 4, "R8 write over user");
        build(va, 52'h3000, FULL, FP | FW, FULL, FULL | FX);
        walk(va, 2'd2, 2'd3, '0, 3'd4, 3'd1, 4, "R8 user over nx");

        // R9 stalled memory and slow answers
        stall_mode = 1'b1; lat = 3;
        va = 64'h0000_7FFF_FFFF_F008; pf = 52'h0_FFFF_FFFF_F000;
        build(va, pf, FULL, FULL, FULL, FULL);
        walk(va, 2'd1, 2'd3, {pf[51:12], va[11:0]}, 3'd0, 3'd1, 4, "R9 stalled success");
        for (int i = 0; i < 4; i++)
            check($sformatf("R9 R1 stalled address level %0d", 4 - i), 64'(rd_log[i]), 64'(exp_rd[i]));
        build(va, pf, FULL, 64'h0, FULL, FULL);
        walk(va, 2'd0, 2'd0, '0, 3'd2, 3'd3, 2, "R9 stalled np level3");
        stall_mode = 1'b0; lat = 1;

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule